// File: doc/BRIEF.md
# Reset and Exception Vector Sequencer

This block decides when a processor core enters reset and how it reaches the first instruction of a handler. It accepts two reset sources. The first is an external active-low reset pin, which counts only after it has stayed low for a minimum number of consecutive clock cycles. The second is a watchdog overflow strobe, which acts at once. While reset is in force, the core is held halted, and the vector base register and the status register are forced to their initial values.

When the pin returns high, the sequencer spends one cycle preparing the reset vector address. It then reads a 32-bit vector word over a request/acknowledge read port and presents the word to the core with a one-cycle program-counter load strobe. After that the core runs. In the run state, an exception request is accepted only when no fetch is in progress. The table address for an exception is the vector number times four. For ordinary sources that offset is added to the vector base register. The reset vector and the address-error vector use the offset alone.

The controller has five states: HOLD (reset active), INIT (prepare the reset vector), FETCH (read request outstanding), LOAD (program-counter strobe) and RUN. Its transitions are:
- HOLD→INIT when the pin is high.
- INIT→FETCH unconditionally.
- FETCH→LOAD on acknowledge.
- LOAD→RUN unconditionally.
- RUN→FETCH on an accepted exception.
- Any state→HOLD on a qualified pin reset or a watchdog strobe. This transition takes priority over all the others.

Top module: `rst_vec_seq`

## Requirements
- R1: The reset vector (number 0) and the address-error vector (number 9) are fetched from address number×4, whatever the vector base register holds.
- R2: Every other exception vector is fetched from vector base register + number×4, modulo 2^32.
- R3: Reset overrides everything. While `rst_active` is 1, `core_halt` is 1 and `rd_req`, `pc_load` and `exc_ack` are 0. A reset taken during a fetch drops `rd_req` on the next cycle.
- R4: When `rst_pin_n` is sampled low on 20 consecutive clock edges, `rst_active` is 1 after the 20th edge. Any high sample restarts the count, so a pulse of 19 cycles or fewer has no effect.
- R5: When `wdt_ovf` is high at a clock edge, `rst_active` is 1 after that edge.
- R6: While `rst_active` is 1, `vbr` is 0 and `st_q` is 7'h0F. In `st_q`, bit 0 is the condition-code interrupt mask, bits 3:1 are the extended-status interrupt mask, bit 4 is the trace enable and bits 6:5 are the interrupt control mode.
- R7: After reset, the interrupt control mode field `st_q[6:5]` is 0 until it is written in RUN.
- R8: Each state change takes one clock edge. On the first edge with the pin high, HOLD moves to INIT. On the next edge, INIT moves to FETCH and `rd_req` rises. On the edge where `rd_ack` is high, FETCH moves to LOAD, and `pc_load` is high for one cycle with `pc_value` equal to the `rd_data` captured at that edge. On the next edge, LOAD moves to RUN and `core_halt` falls.
- R9: `rd_req` stays high with a stable `rd_addr` until `rd_ack` arrives.
- R10: `exc_ack` equals `exc_req` in RUN when no reset is being taken, and is 0 otherwise. A request that is not acknowledged has no effect.
- R11: Writes to `vbr` and `st_q` take effect only in RUN and are ignored in every other state. A write made in the same cycle as an accepted exception affects later exceptions, not that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset of the sequencer itself, active low, asynchronous |
| rst_pin_n | input | 1 | External reset pin, active low, qualified by length |
| wdt_ovf | input | 1 | Watchdog overflow strobe, forces reset |
| exc_req | input | 1 | Exception request from the core |
| exc_num | input | 8 | Vector number of the requested exception |
| exc_ack | output | 1 | Exception accepted this cycle |
| vbr_wr | input | 1 | Vector base register write strobe |
| vbr_wdata | input | 32 | Vector base register write data |
| st_wr | input | 1 | Status register write strobe |
| st_wdata | input | 7 | Status register write data (layout as in R6) |
| rd_req | output | 1 | Vector read request |
| rd_addr | output | 32 | Vector read address |
| rd_ack | input | 1 | Vector read acknowledge, data valid |
| rd_data | input | 32 | Vector read data |
| pc_load | output | 1 | One-cycle strobe that loads the program counter |
| pc_value | output | 32 | Value to load into the program counter |
| core_halt | output | 1 | Core stalled (any state other than RUN) |
| rst_active | output | 1 | Reset in force (HOLD state) |
| vbr | output | 32 | Current vector base register |
| st_q | output | 7 | Current status register |

## Verification
The following properties are checked on every cycle:
- The halt, request and strobe relations while reset is active.
- The forced register values during reset.
- The 20-edge pin qualification, tracked by the checker's own counter.
- The immediate watchdog response and the fixed reset-vector address after release.
- Request stability until acknowledge, and the load of the acknowledged word.
- That no exception is accepted while halted.
- That the vector base register cannot change outside RUN.

Some behaviours need a reference model that tracks the register contents, so only the bench's scenarios show them: the base-plus-offset sums, the exemption of the address-error vector, the ignored 19-cycle pulse, the abort of a long fetch by the watchdog, and the rule that a write in the same cycle as an exception applies only to later ones.

// File: rtl/rvs_pkg.sv
package rvs_pkg;

    localparam int ST_W = 7;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_INIT,
        ST_FETCH,
        ST_LOAD,
        ST_RUN
    } rvs_state_e;

    typedef struct packed {
        logic [1:0] int_mode;
        logic       trace;
        logic [2:0] exr_mask;
        logic       ccr_mask;
    } rvs_status_t;

    localparam rvs_status_t STATUS_INIT = '{
        int_mode: 2'd0,
        trace:    1'b0,
        exr_mask: 3'b111,
        ccr_mask: 1'b1
    };

endpackage

// File: rtl/rvs_rst_qual.sv
module rvs_rst_qual #(
    parameter int MIN_LOW = 20
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_n,
    input  logic wdt,
    output logic take_rst
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LAST = CW'(MIN_LOW - 1);

    logic [CW-1:0] low_cnt;

    // consecutive low samples seen before this edge, saturating
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            low_cnt <= '0;
        else if (pin_n)
            low_cnt <= '0;
        else if (low_cnt != LAST)
            low_cnt <= low_cnt + 1'b1;
    end

    assign take_rst = wdt | (!pin_n && (low_cnt == LAST));
endmodule

// File: rtl/rvs_vec_addr.sv
module rvs_vec_addr #(
    parameter int ADDR_W    = 32,
    parameter int VEC_W     = 8,
    parameter int AERR_VEC  = 9
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VEC_W-1:0]  num,
    input  logic              is_reset,
    output logic [ADDR_W-1:0] addr
);
    logic              absolute;
    logic [ADDR_W-1:0] offset;

    assign absolute = is_reset | (num == VEC_W'(AERR_VEC));
    assign offset   = ADDR_W'({num, 2'b00});
    assign addr     = (absolute ? '0 : base) + offset;
endmodule

// File: rtl/rvs_regs.sv
module rvs_regs #(
    parameter int ADDR_W = 32
) (
    input  logic                   clk,
    input  logic                   por_n,
    input  logic                   clear,
    input  logic                   vbr_we,
    input  logic [ADDR_W-1:0]      vbr_d,
    input  logic                   st_we,
    input  rvs_pkg::rvs_status_t   st_d,
    output logic [ADDR_W-1:0]      vbr_q,
    output rvs_pkg::rvs_status_t   st_q
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            vbr_q <= '0;
            st_q  <= rvs_pkg::STATUS_INIT;
        end else if (clear) begin
            vbr_q <= '0;
            st_q  <= rvs_pkg::STATUS_INIT;
        end else begin
            if (vbr_we) vbr_q <= vbr_d;
            if (st_we)  st_q  <= st_d;
        end
    end
endmodule

// File: rtl/rst_vec_seq.sv
module rst_vec_seq #(
    parameter int ADDR_W    = 32,
    parameter int VEC_W     = 8,
    parameter int MIN_LOW   = 20,
    parameter int RESET_VEC = 0,
    parameter int AERR_VEC  = 9
) (
    input  logic                     clk,
    input  logic                     por_n,
    input  logic                     rst_pin_n,
    input  logic                     wdt_ovf,
    input  logic                     exc_req,
    input  logic [VEC_W-1:0]         exc_num,
    output logic                     exc_ack,
    input  logic                     vbr_wr,
    input  logic [ADDR_W-1:0]        vbr_wdata,
    input  logic                     st_wr,
    input  logic [rvs_pkg::ST_W-1:0] st_wdata,
    output logic                     rd_req,
    output logic [ADDR_W-1:0]        rd_addr,
    input  logic                     rd_ack,
    input  logic [31:0]              rd_data,
    output logic                     pc_load,
    output logic [31:0]              pc_value,
    output logic                     core_halt,
    output logic                     rst_active,
    output logic [ADDR_W-1:0]        vbr,
    output logic [rvs_pkg::ST_W-1:0] st_q
);
    import rvs_pkg::*;

    rvs_state_e        state_q, state_d;
    logic              take_rst;
    logic [VEC_W-1:0]  sel_num;
    logic [ADDR_W-1:0] calc_addr;
    logic [ADDR_W-1:0] fetch_addr_q;
    logic [31:0]       vec_word_q;
    logic              in_run, in_init, addr_latch;
    rvs_status_t       st_cur;

    rvs_rst_qual #(.MIN_LOW(MIN_LOW)) u_qual (
        .clk      (clk),
        .por_n    (por_n),
        .pin_n    (rst_pin_n),
        .wdt      (wdt_ovf),
        .take_rst (take_rst)
    );

    assign in_run  = (state_q == ST_RUN);
    assign in_init = (state_q == ST_INIT);
    assign sel_num = in_init ? VEC_W'(RESET_VEC) : exc_num;

    rvs_vec_addr #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .AERR_VEC(AERR_VEC)) u_addr (
        .base     (vbr),
        .num      (sel_num),
        .is_reset (in_init),
        .addr     (calc_addr)
    );

    rvs_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .por_n  (por_n),
        .clear  (state_d == ST_HOLD),
        .vbr_we (in_run && vbr_wr),
        .vbr_d  (vbr_wdata),
        .st_we  (in_run && st_wr),
        .st_d   (rvs_status_t'(st_wdata)),
        .vbr_q  (vbr),
        .st_q   (st_cur)
    );

    assign st_q = st_cur;

    // next state: reset sources win over every transition
    always_comb begin
        state_d = state_q;
        if (take_rst) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD:  if (rst_pin_n) state_d = ST_INIT;
                ST_INIT:  state_d = ST_FETCH;
                ST_FETCH: if (rd_ack) state_d = ST_LOAD;
                ST_LOAD:  state_d = ST_RUN;
                ST_RUN:   if (exc_req) state_d = ST_FETCH;
                default:  state_d = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    assign addr_latch = !take_rst && (in_init || (in_run && exc_req));

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            fetch_addr_q <= '0;
            vec_word_q   <= '0;
        end else begin
            if (addr_latch) fetch_addr_q <= calc_addr;
            if (state_q == ST_FETCH && rd_ack && !take_rst) vec_word_q <= rd_data;
        end
    end

    // outputs decoded from the current state
    always_comb begin
        rst_active = (state_q == ST_HOLD);
        core_halt  = !in_run;
        rd_req     = (state_q == ST_FETCH);
        rd_addr    = fetch_addr_q;
        pc_load    = (state_q == ST_LOAD);
        pc_value   = vec_word_q;
        exc_ack    = in_run && exc_req && !take_rst;
    end
endmodule

// File: rtl/rvs_seq_chk.sv
module rvs_seq_chk #(
    parameter int ADDR_W    = 32,
    parameter int MIN_LOW   = 20,
    parameter int RESET_VEC = 0
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_pin_n,
    input logic              wdt_ovf,
    input logic              exc_req,
    input logic              exc_ack,
    input logic              vbr_wr,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic [31:0]       rd_data,
    input logic              pc_load,
    input logic [31:0]       pc_value,
    input logic              core_halt,
    input logic              rst_active,
    input logic [ADDR_W-1:0] vbr,
    input logic [6:0]        st_q
);
    localparam int CW = $clog2(MIN_LOW + 1);
    logic [CW-1:0] low_run;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)               low_run <= '0;
        else if (rst_pin_n)       low_run <= '0;
        else if (low_run != CW'(MIN_LOW - 1)) low_run <= low_run + 1'b1;
    end

    a_r3_halt_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        rst_active |-> (core_halt && !rd_req && !pc_load && !exc_ack));

    a_r4_long_low_resets: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_pin_n && low_run == CW'(MIN_LOW - 1)) |=> rst_active);

    a_r4_high_pin_no_entry: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_active && rst_pin_n && !wdt_ovf) |=> !rst_active);

    a_r5_watchdog: assert property (@(posedge clk) disable iff (!por_n)
        wdt_ovf |=> rst_active);

    a_r6_forced_values: assert property (@(posedge clk) disable iff (!por_n)
        rst_active |-> (vbr == '0 && st_q == 7'h0F));

    a_r1_reset_vec_addr: assert property (@(posedge clk) disable iff (!por_n)
        (rst_active && rst_pin_n && !wdt_ovf) ##1 (rst_pin_n && !wdt_ovf)
            |=> (rd_req && rd_addr == ADDR_W'(RESET_VEC * 4)));

    a_r9_req_held: assert property (@(posedge clk) disable iff (!por_n)
        (rd_req && !rd_ack && rst_pin_n && !wdt_ovf) |=> (rd_req && $stable(rd_addr)));

    a_r8_load_word: assert property (@(posedge clk) disable iff (!por_n)
        (rd_req && rd_ack && rst_pin_n && !wdt_ovf) |=> (pc_load && pc_value == $past(rd_data)));

    a_r10_ack_only_running: assert property (@(posedge clk) disable iff (!por_n)
        exc_ack |-> (exc_req && !core_halt));

    a_r11_vbr_locked: assert property (@(posedge clk) disable iff (!por_n)
        (vbr_wr && core_halt && rst_pin_n && !wdt_ovf) |=> $stable(vbr));
endmodule

bind rst_vec_seq rvs_seq_chk #(
    .ADDR_W    (ADDR_W),
    .MIN_LOW   (MIN_LOW),
    .RESET_VEC (RESET_VEC)
) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .rst_pin_n  (rst_pin_n),
    .wdt_ovf    (wdt_ovf),
    .exc_req    (exc_req),
    .exc_ack    (exc_ack),
    .vbr_wr     (vbr_wr),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_ack     (rd_ack),
    .rd_data    (rd_data),
    .pc_load    (pc_load),
    .pc_value   (pc_value),
    .core_halt  (core_halt),
    .rst_active (rst_active),
    .vbr        (vbr),
    .st_q       (st_q)
);

// File: tb/rst_vec_seq_bench.sv
module rst_vec_seq_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_pin_n = 1'b0;
    logic        wdt_ovf = 1'b0;
    logic        exc_req = 1'b0;
    logic [7:0]  exc_num = '0;
    logic        exc_ack;
    logic        vbr_wr = 1'b0;
    logic [31:0] vbr_wdata = '0;
    logic        st_wr = 1'b0;
    logic [6:0]  st_wdata = '0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [31:0] rd_data = '0;
    logic        pc_load;
    logic [31:0] pc_value;
    logic        core_halt;
    logic        rst_active;
    logic [31:0] vbr;
    logic [6:0]  st_q;

    int checks = 0;
    int errors = 0;
    int lat = 1;
    int wait_cnt = 0;
    logic [31:0] last_addr = '0;
    logic [31:0] last_pc = '0;
    bit done = 0;

    always #5 clk = ~clk;

    rst_vec_seq u_rst_vec_seq (.*);

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return 32'h8000_0003 | (a << 4);
    endfunction

    // memory responder: acknowledges after lat request cycles
    always @(posedge clk) begin
        #1;
        if (rd_req && !rd_ack) begin
            if (wait_cnt + 1 >= lat) begin
                rd_ack  = 1'b1;
                rd_data = mem_word(rd_addr);
                wait_cnt = 0;
            end else begin
                wait_cnt++;
            end
        end else begin
            rd_ack = 1'b0;
            if (!rd_req) wait_cnt = 0;
        end
    end

    always @(posedge clk) begin
        if (rd_req && rd_ack) last_addr = rd_addr;
        if (pc_load)          last_pc   = pc_value;
    end

    // behavioural reference model: 0 hold, 1 init, 2 fetch, 3 load, 4 run
    int          m_st = 0;
    int          m_low = 0;
    logic [31:0] m_vbr = '0;
    logic [6:0]  m_sr = 7'h0F;
    logic [31:0] m_addr = '0;
    logic [31:0] m_word = '0;

    function automatic bit m_take();
        return wdt_ovf || (!rst_pin_n && m_low >= 19);
    endfunction

    always @(posedge clk) begin
        bit t;
        int nxt;
        t = m_take();
        if (!por_n) begin
            m_st = 0; m_low = 0; m_vbr = '0; m_sr = 7'h0F;
            m_addr = '0; m_word = '0;
        end else begin
            nxt = m_st;
            if (t) nxt = 0;
            else if (m_st == 0) begin if (rst_pin_n) nxt = 1; end
            else if (m_st == 1) begin m_addr = 32'h0; nxt = 2; end
            else if (m_st == 2) begin if (rd_ack) begin m_word = rd_data; nxt = 3; end end
            else if (m_st == 3) nxt = 4;
            else begin
                if (exc_req) begin
                    m_addr = ((exc_num == 8'd9) ? 32'h0 : m_vbr) + 32'(exc_num) * 4;
                    nxt = 2;
                end
                if (vbr_wr) m_vbr = vbr_wdata;
                if (st_wr)  m_sr  = st_wdata;
            end
            if (nxt == 0) begin m_vbr = '0; m_sr = 7'h0F; end
            m_st = nxt;
            m_low = rst_pin_n ? 0 : ((m_low < 19) ? m_low + 1 : 19);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (por_n && !done) begin
            chk(rst_active == (m_st == 0), "R3 rst_active", 32'(rst_active), 32'(m_st == 0));
            chk(core_halt == (m_st != 4), "R10 core_halt", 32'(core_halt), 32'(m_st != 4));
            chk(rd_req == (m_st == 2), "R9 rd_req", 32'(rd_req), 32'(m_st == 2));
            if (m_st == 2) chk(rd_addr == m_addr, "R2 rd_addr", rd_addr, m_addr);
            chk(pc_load == (m_st == 3), "R8 pc_load", 32'(pc_load), 32'(m_st == 3));
            if (m_st == 3) chk(pc_value == m_word, "R8 pc_value", pc_value, m_word);
            chk(exc_ack == (m_st == 4 && exc_req && !m_take()), "R10 exc_ack",
                32'(exc_ack), 32'(m_st == 4 && exc_req && !m_take()));
            chk(vbr == m_vbr, "R11 vbr", vbr, m_vbr);
            chk(st_q == m_sr, "R6 st_q", 32'(st_q), 32'(m_sr));
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic wait_run();
        for (int i = 0; i < 300 && core_halt; i++) step(1);
    endtask

    task automatic raise(input logic [7:0] num);
        exc_num = num; exc_req = 1'b1; step(1); exc_req = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #500000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(3);
        chk(rst_active === 1'b1, "R3 reset state", 32'(rst_active), 1);
        chk(st_q === 7'h0F && vbr === 0, "R6 init values", 32'(st_q), 32'h0F);
        por_n = 1'b1;
        step(5);
        chk(rst_active && core_halt && !rd_req, "R3 held while pin low", 32'(rd_req), 0);
        chk(st_q[6:5] == 2'd0, "R7 mode zero", 32'(st_q[6:5]), 0);
        rst_pin_n = 1'b1;
        wait_run();
        chk(last_addr == 32'h0, "R1 reset vector address", last_addr, 0);
        chk(last_pc == mem_word(0), "R8 reset pc", last_pc, mem_word(0));

        vbr_wr = 1; vbr_wdata = 32'h0000_1000; st_wr = 1; st_wdata = 7'h60;
        step(1); vbr_wr = 0; st_wr = 0;
        chk(vbr == 32'h1000 && st_q == 7'h60, "R11 write in run", vbr, 32'h1000);

        raise(8'd24); wait_run();
        chk(last_addr == 32'h1060, "R2 relocated vector", last_addr, 32'h1060);
        chk(last_pc == mem_word(32'h1060), "R8 exception pc", last_pc, mem_word(32'h1060));

        raise(8'd9); wait_run();
        chk(last_addr == 32'd36, "R1 address error ignores base", last_addr, 36);

        lat = 6;
        raise(8'd30);
        step(1);
        vbr_wr = 1; vbr_wdata = 32'h2000; st_wr = 1; st_wdata = 7'h01;
        exc_req = 1; exc_num = 8'd7;
        step(1);
        chk(exc_ack == 0, "R10 held off in fetch", 32'(exc_ack), 0);
        vbr_wr = 0; st_wr = 0; exc_req = 0;
        wait_run();
        chk(vbr == 32'h1000 && st_q == 7'h60, "R11 write ignored in fetch", vbr, 32'h1000);
        lat = 1;

        exc_num = 8'd2; exc_req = 1; vbr_wr = 1; vbr_wdata = 32'h3000;
        step(1); exc_req = 0; vbr_wr = 0;
        wait_run();
        chk(last_addr == 32'h1008, "R11 same-cycle write uses old base", last_addr, 32'h1008);
        chk(vbr == 32'h3000, "R11 write kept", vbr, 32'h3000);

        rst_pin_n = 0; step(19);
        chk(rst_active == 0, "R4 19-cycle pulse ignored", 32'(rst_active), 0);
        rst_pin_n = 1; step(2);
        chk(vbr == 32'h3000 && !core_halt, "R4 state kept after short pulse", vbr, 32'h3000);

        rst_pin_n = 0; step(20);
        chk(rst_active == 1, "R4 20-cycle pulse resets", 32'(rst_active), 1);
        chk(vbr == 0 && st_q == 7'h0F, "R6 cleared by pin reset", 32'(st_q), 32'h0F);
        rst_pin_n = 1; wait_run();

        st_wr = 1; st_wdata = 7'h7E; step(1); st_wr = 0;
        wdt_ovf = 1; step(1); wdt_ovf = 0;
        chk(rst_active == 1, "R5 watchdog reset", 32'(rst_active), 1);
        chk(st_q == 7'h0F, "R7 mode cleared by watchdog", 32'(st_q), 32'h0F);
        wait_run();

        lat = 30;
        raise(8'd24); step(3);
        wdt_ovf = 1; step(1); wdt_ovf = 0;
        chk(rd_req == 0 && rst_active == 1, "R3 fetch aborted by reset", 32'(rd_req), 0);
        lat = 1;
        wait_run();
        chk(!core_halt && last_addr == 0, "R8 recovery after abort", last_addr, 0);

        step(3);
        finish_run();
    end
endmodule